// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits between a software-visible 16-bit control word and a behavioural flash array. Software writes an operation code into the lower fifteen bits. It sets bit 15, the start bit, either in the same write or in a later one. The sequencer decodes the code into one class of operation: a region erase with its segment side effects, a page erase, a row program, a single-word program or a configuration-byte write. It then drives one-cycle strobes towards the array and keeps the start bit high for a parameter-set number of cycles. When that count runs out, the start bit drops by itself, and software polls it to learn that the operation has finished.

A row program reads its words from an internal latch buffer. The buffer is filled beforehand through a separate write port, and its words are issued on consecutive cycles with ascending addresses. While the start bit is high, the control word accepts no writes. A start with an unknown code fires no strobe, ends after one cycle and sets a sticky error flag.

Top module: `nvm_cmd_seq`

## Requirements
- R1: After reset `ctl_rdata` is 0, `err_flag` is 0 and no strobe is active. A write with bit 15 clear stores bits [14:0] as the operation field, readable on `ctl_rdata[14:0]`, and leaves `ctl_rdata[15]` at 0.
- R2: A write with bit 15 set launches the operation, and `ctl_rdata[15]` is 1 for exactly the class duration, then clears without software action. The durations are REGION_CYC for 0x404F/0x404D/0x404C, PAGE_CYC for 0x4042, ROW_CYC for 0x4001 and SINGLE_CYC for 0x4003/0x4000.
- R3: Code 0x404F gives one `erase_stb` pulse in the first busy cycle with `erase_mask` = 0x07. In the mask, bit 0 is code memory, bit 1 is executive memory and bit 2 is the code-protection configuration registers. The mask has no bit for the unit-ID or device-ID storage.
- R4: Code 0x404D gives one `erase_stb` pulse with `erase_mask` = 0x18. Bit 3 is the general segment and bit 4 is its configuration register.
- R5: Code 0x404C gives one `erase_stb` pulse with `erase_mask` = 0x78. This is the secure segment (bit 5) and its configuration register (bit 6), together with the general segment and its configuration register (bits 3 and 4).
- R6: Code 0x4042 gives one `page_erase_stb` pulse in the first busy cycle, with `op_addr` equal to `tgt_addr` as sampled at the launch write.
- R7: Code 0x4001 gives `word_stb` on ROW_WORDS consecutive cycles from the first busy cycle. On cycle i, `op_addr` = base + i and `op_data` = latch entry i.
- R8: Code 0x4003 gives one `word_stb` with `op_data` = latch entry 0. Code 0x4000 gives one `cfg_byte_stb` with `op_data[7:0]` = the low byte of latch entry 0.
- R9: While `ctl_rdata[15]` is 1, control writes are ignored: the operation field is unchanged, no new strobe fires and the busy time is not extended.
- R10: A start with any other code fires no strobe and holds `ctl_rdata[15]` for one cycle. It sets `err_flag` from the next cycle, and `err_flag` stays set until the next accepted control write clears it.
- R11: `lat_we` writes `lat_wdata` into latch entry `lat_idx`. A row program later reads that value back on `op_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | 16 | Control write data; bit 15 is start |
| ctl_rdata | output | 16 | {start/busy, operation field} |
| err_flag | output | 1 | Sticky unknown-code flag |
| tgt_addr | input | ADDR_W | Target address, sampled at launch |
| lat_we | input | 1 | Latch buffer write enable |
| lat_idx | input | $clog2(ROW_WORDS) | Latch entry index |
| lat_wdata | input | DATA_W | Latch write data |
| erase_stb | output | 1 | Region erase strobe |
| erase_mask | output | 7 | Regions erased by this strobe |
| page_erase_stb | output | 1 | Page erase strobe |
| word_stb | output | 1 | Program one word strobe |
| cfg_byte_stb | output | 1 | Configuration byte write strobe |
| op_addr | output | ADDR_W | Address for the current strobe |
| op_data | output | DATA_W | Data for the current strobe |

## Verification
The hardest state to reach is a control write that arrives while an operation is still counting down. The write has to be both discarded and prevented from stretching the busy window or firing a second strobe. The bench launches a page erase and, partway through, writes a different start command and a plain field value. It then checks that the field still reads 0x4042, that no region-erase strobe appeared and that the total busy time still equals PAGE_CYC. A second hard case is the full row burst. The latch is loaded with an index-dependent pattern, and each of the 64 word strobes is compared against its own address and data.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [2:0] {
    CL_NONE   = 3'd0,
    CL_REGION = 3'd1,
    CL_PAGE   = 3'd2,
    CL_ROW    = 3'd3,
    CL_WORD   = 3'd4,
    CL_BYTE   = 3'd5,
    CL_BAD    = 3'd6
  } op_class_e;

  localparam int MASK_W = 7;

  // erase region mask bit positions
  localparam int RG_CODE    = 0;
  localparam int RG_EXEC    = 1;
  localparam int RG_CP_CFG  = 2;
  localparam int RG_GEN     = 3;
  localparam int RG_GEN_CFG = 4;
  localparam int RG_SEC     = 5;
  localparam int RG_SEC_CFG = 6;

  localparam logic [14:0] OPC_ERASE_ALL = 15'h404F;
  localparam logic [14:0] OPC_ERASE_GEN = 15'h404D;
  localparam logic [14:0] OPC_ERASE_SEC = 15'h404C;
  localparam logic [14:0] OPC_ERASE_PG  = 15'h4042;
  localparam logic [14:0] OPC_PROG_ROW  = 15'h4001;
  localparam logic [14:0] OPC_PROG_WORD = 15'h4003;
  localparam logic [14:0] OPC_CFG_BYTE  = 15'h4000;

endpackage

// File: rtl/nvm_cmd_decode.sv
module nvm_cmd_decode
  import nvm_seq_pkg::*;
(
  input  logic [14:0]       opc,
  output op_class_e         cls,
  output logic [MASK_W-1:0] mask
);

  always_comb begin
    mask = '0;
    unique case (opc)
      OPC_ERASE_ALL: begin
        cls = CL_REGION;
        mask[RG_CODE]   = 1'b1;
        mask[RG_EXEC]   = 1'b1;
        mask[RG_CP_CFG] = 1'b1;
      end
      OPC_ERASE_GEN: begin
        cls = CL_REGION;
        mask[RG_GEN]     = 1'b1;
        mask[RG_GEN_CFG] = 1'b1;
      end
      OPC_ERASE_SEC: begin
        cls = CL_REGION;
        mask[RG_GEN]     = 1'b1;
        mask[RG_GEN_CFG] = 1'b1;
        mask[RG_SEC]     = 1'b1;
        mask[RG_SEC_CFG] = 1'b1;
      end
      OPC_ERASE_PG:  cls = CL_PAGE;
      OPC_PROG_ROW:  cls = CL_ROW;
      OPC_PROG_WORD: cls = CL_WORD;
      OPC_CFG_BYTE:  cls = CL_BYTE;
      default:       cls = CL_BAD;
    endcase
  end

endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] dur,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);

  logic             busy_d;
  logic [CNT_W-1:0] cnt_d, lim_q, lim_d;
  logic             last;

  assign last = (cnt == lim_q - CNT_W'(1));

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt;
    lim_d  = lim_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      lim_d  = dur;
    end else if (busy) begin
      if (last) busy_d = 1'b0;
      else      cnt_d  = cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      lim_q <= '0;
    end else begin
      busy  <= busy_d;
      cnt   <= cnt_d;
      lim_q <= lim_d;
    end
  end

  a_r2_hold_until_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);

  a_r2_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last && !load) |=> !busy);

endmodule

// File: rtl/nvm_row_latch.sv
module nvm_row_latch #(
  parameter int WORDS  = 64,
  parameter int DATA_W = 24,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];

  a_r11_latch_store: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 24,
  parameter int ROW_WORDS  = 64,
  parameter int REGION_CYC = 400,
  parameter int PAGE_CYC   = 200,
  parameter int ROW_CYC    = 600,
  parameter int SINGLE_CYC = 50,
  localparam int IDX_W     = $clog2(ROW_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [15:0]       ctl_wdata,
  output logic [15:0]       ctl_rdata,
  output logic              err_flag,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              lat_we,
  input  logic [IDX_W-1:0]  lat_idx,
  input  logic [DATA_W-1:0] lat_wdata,
  output logic              erase_stb,
  output logic [6:0]        erase_mask,
  output logic              page_erase_stb,
  output logic              word_stb,
  output logic              cfg_byte_stb,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);

  localparam int MAX_A   = (REGION_CYC > PAGE_CYC) ? REGION_CYC : PAGE_CYC;
  localparam int MAX_B   = (ROW_CYC > SINGLE_CYC) ? ROW_CYC : SINGLE_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  // control state
  logic [14:0]       op_q, op_d;
  logic              err_q, err_d;
  op_class_e         cls_q, cls_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic [ADDR_W-1:0] base_q, base_d;

  op_class_e         dec_cls;
  logic [MASK_W-1:0] dec_mask;
  logic              busy, accept, launch, first, row_live, is_row;
  logic [CNT_W-1:0]  cnt, dur;
  logic [IDX_W-1:0]  rd_idx;

  nvm_cmd_decode u_dec (
    .opc  (ctl_wdata[14:0]),
    .cls  (dec_cls),
    .mask (dec_mask)
  );

  assign accept = ctl_we && !busy;
  assign launch = accept && ctl_wdata[15];

  always_comb begin
    unique case (dec_cls)
      CL_REGION:      dur = CNT_W'(REGION_CYC);
      CL_PAGE:        dur = CNT_W'(PAGE_CYC);
      CL_ROW:         dur = CNT_W'(ROW_CYC);
      CL_WORD, CL_BYTE: dur = CNT_W'(SINGLE_CYC);
      default:        dur = CNT_W'(1);
    endcase
  end

  always_comb begin
    op_d   = op_q;
    err_d  = err_q;
    cls_d  = cls_q;
    mask_d = mask_q;
    base_d = base_q;
    if (accept) begin
      op_d  = ctl_wdata[14:0];
      err_d = launch && (dec_cls == CL_BAD);
      if (launch) begin
        cls_d  = dec_cls;
        mask_d = dec_mask;
        base_d = tgt_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      err_q  <= 1'b0;
      cls_q  <= CL_NONE;
      mask_q <= '0;
      base_q <= '0;
    end else begin
      op_q   <= op_d;
      err_q  <= err_d;
      cls_q  <= cls_d;
      mask_q <= mask_d;
      base_q <= base_d;
    end
  end

  nvm_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (launch),
    .dur   (dur),
    .busy  (busy),
    .cnt   (cnt)
  );

  assign is_row   = (cls_q == CL_ROW);
  assign rd_idx   = is_row ? cnt[IDX_W-1:0] : '0;

  nvm_row_latch #(.WORDS(ROW_WORDS), .DATA_W(DATA_W)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (lat_we),
    .widx  (lat_idx),
    .wdata (lat_wdata),
    .ridx  (rd_idx),
    .rdata (op_data)
  );

  assign first          = busy && (cnt == '0);
  assign row_live       = busy && is_row && (cnt < CNT_W'(ROW_WORDS));
  assign erase_stb      = first && (cls_q == CL_REGION);
  assign erase_mask     = erase_stb ? mask_q : '0;
  assign page_erase_stb = first && (cls_q == CL_PAGE);
  assign word_stb       = row_live || (first && (cls_q == CL_WORD));
  assign cfg_byte_stb   = first && (cls_q == CL_BYTE);
  assign op_addr        = base_q + (is_row ? ADDR_W'(cnt) : '0);
  assign ctl_rdata      = {busy, op_q};
  assign err_flag       = err_q;

  a_r9_field_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (op_q == $past(op_q)));

  a_r7_row_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && is_row && cnt != '0) |-> (op_addr == $past(op_addr) + ADDR_W'(1)));

  a_r10_bad_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cls_q == CL_BAD) |-> !(erase_stb || page_erase_stb || word_stb || cfg_byte_stb));

  a_r10_bad_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && dec_cls == CL_BAD) |=> (err_flag && busy));

  a_r3_one_strobe_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_stb, page_erase_stb, word_stb, cfg_byte_stb}));

endmodule

// File: tb/tb_nvm_cmd_seq.sv
module tb_nvm_cmd_seq;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 24;
  localparam int WORDS  = 64;
  localparam int RG_C   = 12;
  localparam int PG_C   = 7;
  localparam int ROW_C  = 70;
  localparam int SGL_C  = 4;
  localparam int NVEC   = 9;

  // {cmd16, mask7, cycles8, n_erase8, n_page8, n_word8, n_cfg8, err1}
  localparam logic [63:0] VEC [NVEC] = '{
    {16'hC04F, 7'h07, 8'(RG_C),  8'd1, 8'd0, 8'd0,       8'd0, 1'b0}, // R3
    {16'hC04D, 7'h18, 8'(RG_C),  8'd1, 8'd0, 8'd0,       8'd0, 1'b0}, // R4
    {16'hC04C, 7'h78, 8'(RG_C),  8'd1, 8'd0, 8'd0,       8'd0, 1'b0}, // R5
    {16'hC042, 7'h00, 8'(PG_C),  8'd0, 8'd1, 8'd0,       8'd0, 1'b0}, // R6
    {16'hC001, 7'h00, 8'(ROW_C), 8'd0, 8'd0, 8'(WORDS),  8'd0, 1'b0}, // R7
    {16'hC003, 7'h00, 8'(SGL_C), 8'd0, 8'd0, 8'd1,       8'd0, 1'b0}, // R8
    {16'hC000, 7'h00, 8'(SGL_C), 8'd0, 8'd0, 8'd0,       8'd1, 1'b0}, // R8
    {16'hC0FF, 7'h00, 8'd1,      8'd0, 8'd0, 8'd0,       8'd0, 1'b1}, // R10
    {16'hC04E, 7'h00, 8'd1,      8'd0, 8'd0, 8'd0,       8'd0, 1'b1}  // R10
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ctl_we;
  logic [15:0]       ctl_wdata;
  logic [15:0]       ctl_rdata;
  logic              err_flag;
  logic [ADDR_W-1:0] tgt_addr;
  logic              lat_we;
  logic [5:0]        lat_idx;
  logic [DATA_W-1:0] lat_wdata;
  logic              erase_stb;
  logic [6:0]        erase_mask;
  logic              page_erase_stb;
  logic              word_stb;
  logic              cfg_byte_stb;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  nvm_cmd_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_WORDS(WORDS),
    .REGION_CYC(RG_C), .PAGE_CYC(PG_C), .ROW_CYC(ROW_C), .SINGLE_CYC(SGL_C)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .err_flag(err_flag), .tgt_addr(tgt_addr),
    .lat_we(lat_we), .lat_idx(lat_idx), .lat_wdata(lat_wdata),
    .erase_stb(erase_stb), .erase_mask(erase_mask),
    .page_erase_stb(page_erase_stb), .word_stb(word_stb),
    .cfg_byte_stb(cfg_byte_stb), .op_addr(op_addr), .op_data(op_data)
  );

  function automatic logic [DATA_W-1:0] pat(input int i);
    return 24'h5A0000 ^ DATA_W'(i * 24'h001357);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [15:0] w);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = w;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // launch, then count busy cycles and strobes; checks addr/data per strobe
  task automatic run_op(input logic [15:0] cmd, input string req,
                        output int cyc, output int ne, output int np,
                        output int nw, output int nc, output logic [6:0] mk);
    cyc = 0; ne = 0; np = 0; nw = 0; nc = 0; mk = '0;
    ctl_write(cmd);
    while (ctl_rdata[15] && cyc < 1000) begin
      if (erase_stb) begin ne++; mk = erase_mask; end
      if (page_erase_stb) begin
        np++;
        check({req, " page addr"}, 32'(op_addr), 32'(tgt_addr));
      end
      if (word_stb) begin
        check({req, " word addr"}, 32'(op_addr), 32'(tgt_addr + ADDR_W'(nw)));
        check({req, " word data"}, 32'(op_data), 32'(pat(nw)));
        nw++;
      end
      if (cfg_byte_stb) begin
        nc++;
        check({req, " cfg byte"}, 32'(op_data[7:0]), 32'(pat(0) & 24'hFF));
      end
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc, ne, np, nw, nc;
    logic [6:0] mk;
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; tgt_addr = '0;
    lat_we = 1'b0; lat_idx = '0; lat_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reset rdata", 32'(ctl_rdata), 32'h0);
    check("R1 reset err", 32'(err_flag), 32'h0);
    check("R1 reset strobes", 32'({erase_stb, page_erase_stb, word_stb, cfg_byte_stb}), 32'h0);

    // R11 fill latch
    for (int i = 0; i < WORDS; i++) begin
      lat_we = 1'b1; lat_idx = 6'(i); lat_wdata = pat(i);
      @(negedge clk);
    end
    lat_we = 1'b0;

    // table walk: R2..R8, R10
    for (int v = 0; v < NVEC; v++) begin
      logic [63:0] e;
      e = VEC[v];
      tgt_addr = 16'h1F00 + ADDR_W'(v * 16'h0100);
      run_op(e[63:48], "R2", cyc, ne, np, nw, nc, mk);
      check("R2 busy cycles", 32'(cyc), 32'(e[40:33]));
      check("R3 R4 R5 erase count", 32'(ne), 32'(e[32:25]));
      check("R3 R4 R5 erase mask", 32'(mk), 32'(e[47:41]));
      check("R6 page count", 32'(np), 32'(e[24:17]));
      check("R7 R8 word count", 32'(nw), 32'(e[16:9]));
      check("R8 cfg count", 32'(nc), 32'(e[8:1]));
      check("R10 err flag", 32'(err_flag), 32'(e[0]));
      check("R1 field readback", 32'(ctl_rdata), 32'(e[63:48] & 16'h7FFF));
    end

    // R10 sticky: error remains over idle cycles, next write clears it
    repeat (5) @(negedge clk);
    check("R10 err sticky", 32'(err_flag), 32'h1);
    ctl_write(16'h1234);
    check("R10 err cleared", 32'(err_flag), 32'h0);
    check("R1 plain write", 32'(ctl_rdata), 32'h1234);

    // R9 writes during busy ignored
    tgt_addr = 16'h0A40;
    ctl_write(16'hC042);
    cyc = 1; ne = 0;
    @(negedge clk); cyc++;
    ctl_we = 1'b1; ctl_wdata = 16'hC04F;
    if (erase_stb) ne++;
    @(negedge clk); cyc++;
    ctl_wdata = 16'h0123;
    if (erase_stb) ne++;
    @(negedge clk);
    ctl_we = 1'b0;
    while (ctl_rdata[15] && cyc < 100) begin
      if (erase_stb) ne++;
      check("R9 field held", 32'(ctl_rdata[14:0]), 32'h4042);
      cyc++;
      @(negedge clk);
    end
    check("R9 busy not extended", 32'(cyc), 32'(PG_C));
    check("R9 no extra strobe", 32'(ne), 32'h0);
    check("R9 field after", 32'(ctl_rdata), 32'h4042);

    // R7 R11 rewrite one latch entry, rerun row
    lat_we = 1'b1; lat_idx = 6'd5; lat_wdata = 24'hABCDEF;
    @(negedge clk);
    lat_we = 1'b0;
    tgt_addr = 16'h2000;
    ctl_write(16'hC001);
    repeat (5) @(negedge clk);
    check("R11 rewritten entry", 32'(op_data), 32'hABCDEF);
    check("R7 row addr at 5", 32'(op_addr), 32'h2005);
    while (ctl_rdata[15]) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule